// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block keeps two 32-bit words: a sticky event word and an enable mask. Internal logic marks events by pulsing bits of a set vector for one cycle. Software reads both words and writes them through a small word-wide register port with a valid strobe and a write flag. Writing the event word with ones acknowledges those events. Writing the mask word replaces it.

Three level interrupt lines leave the block: transmit, receive and error. Each line is high while at least one event bit is both pending and enabled and also belongs to that line's group. Each group is a fixed bit pattern given as a parameter. The three patterns must be disjoint. Bits that belong to no group are held in the event word but drive no line. The lines are combinational functions of the two registers. They therefore follow any register change at once, including the return to zero at reset.

Top module: `evt_irq_agg`

## Requirements
- R1: With `rst_n` low at a rising edge, both registers become zero on that edge, whatever `hw_set` or the bus carry. All three interrupt lines are then low.
- R2: Every bit that is 1 in `hw_set` at a rising edge is 1 in the event word after that edge. Event bits already set stay set.
- R3: A bus write (`bus_valid`=1, `bus_write`=1) to address 0 clears each event bit that is written as 1. Event bits written as 0 keep their value.
- R4: When the same event bit is set by `hw_set` and cleared by a software write in the same cycle, the bit ends up set.
- R5: A bus write to address 1 replaces all 32 bits of the mask word with `bus_wdata`.
- R6: While `bus_valid`=1 and `bus_write`=0, `bus_rdata` shows the current event word for address 0 and the current mask word for address 1, in the same cycle. It shows zero for any other address, and zero whenever no read is presented.
- R7: `irq_tx`, `irq_rx` and `irq_err` are each the OR of event AND mask AND the group pattern for that line. The default patterns are bits 7:0 for transmit, bits 15:8 for receive and bits 23:16 for error. The lines reflect the registers in the same cycle the registers change.
- R8: An event bit outside all three groups (default bits 31:24) raises no line, even when it is enabled.
- R9: Writes to addresses other than 0 and 1 change neither register.
- R10: Bus writes presented with `bus_valid`=0 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (2) | Word address: 0 = event, 1 = mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| hw_set | input | 32 | One-cycle event set pulses |
| irq_tx | output | 1 | Transmit group interrupt level |
| irq_rx | output | 1 | Receive group interrupt level |
| irq_err | output | 1 | Error group interrupt level |

## Verification
A write or a set pulse takes effect on the next rising edge. From that same edge on, both the read-back value and the three interrupt lines reflect it. So every register effect is due exactly one edge after its stimulus. Read data has no register in its path and is valid in the cycle the read is presented. The bench drives its inputs at the falling edge and checks read data 1 ns later. It then advances its reference model at the rising edge and compares the interrupt lines at the following falling edge, so each value is sampled half a period after it settles.

// File: rtl/evt_irq_pkg.sv
// Package: shared widths, word type and group indices for the event
// interrupt aggregator. Assumes a single 32-bit register width.
package evt_irq_pkg;
    localparam int unsigned AGG_W = 32;
    localparam int unsigned GRP_N = 3;

    typedef logic [AGG_W-1:0] word_t;

    typedef enum int unsigned {
        GRP_TX  = 0,
        GRP_RX  = 1,
        GRP_ERR = 2
    } grp_idx_e;
endpackage

// File: rtl/evt_bank.sv
// Sticky event register. Hardware pulses set bits, software acknowledges
// by writing ones. Assumes set and clear may target the same bit in one
// cycle; the set is applied last so the event survives.
module evt_bank
    import evt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_pulse,
    input  logic  clr_en,
    input  word_t clr_bits,
    output word_t evt_q
);
    word_t clr_vec;

    // Select which bits the software write acknowledges this cycle.
    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
    end

    // Hold events: clear acknowledged bits first, then merge new pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_vec) | set_pulse;
        end
    end
endmodule

// File: rtl/mask_bank.sv
// Interrupt enable mask. A load replaces the whole word. Assumes loads
// come only from the register port.
module mask_bank
    import evt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_en,
    input  word_t load_val,
    output word_t msk_q
);
    // Replace the mask on a load, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk_q <= '0;
        end else if (load_en) begin
            msk_q <= load_val;
        end
    end
endmodule

// File: rtl/group_reduce.sv
// Reduces the active event set into one level per group. Group patterns
// arrive packed, group g in bits [g*AGG_W +: AGG_W]. Assumes the patterns
// are disjoint; an overlap would raise several lines for one bit.
module group_reduce
    import evt_irq_pkg::*;
#(
    parameter int unsigned                 N_GRP   = GRP_N,
    parameter logic [N_GRP*AGG_W-1:0]      GRP_VEC = '0
) (
    input  word_t            active,
    output logic [N_GRP-1:0] grp_hit
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam word_t SEL = GRP_VEC[g*AGG_W +: AGG_W];

        // One line: any active bit inside this group's pattern.
        always_comb begin
            grp_hit[g] = |(active & SEL);
        end
    end
endmodule

// File: rtl/evt_irq_agg.sv
// Top: event and mask registers behind a word port, fanned out into three
// level interrupt lines by fixed group patterns. Assumes single-cycle
// register accesses with no wait states; read data is combinational.
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned EVT_ADDR  = 0,
    parameter int unsigned MSK_ADDR  = 1,
    parameter logic [31:0] TX_GROUP  = 32'h0000_00FF,
    parameter logic [31:0] RX_GROUP  = 32'h0000_FF00,
    parameter logic [31:0] ERR_GROUP = 32'h00FF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       hw_set,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MSK_ADDR);
    localparam logic [GRP_N*AGG_W-1:0] GRP_PACK = {ERR_GROUP, RX_GROUP, TX_GROUP};

    logic              wr_evt;
    logic              wr_msk;
    logic              rd_en;
    word_t             evt_q;
    word_t             msk_q;
    word_t             active;
    logic [GRP_N-1:0]  hit;

    // Decode register-port strobes.
    always_comb begin
        wr_evt = bus_valid && bus_write && (bus_addr == A_EVT);
        wr_msk = bus_valid && bus_write && (bus_addr == A_MSK);
        rd_en  = bus_valid && !bus_write;
    end

    evt_bank u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (hw_set),
        .clr_en    (wr_evt),
        .clr_bits  (bus_wdata),
        .evt_q     (evt_q)
    );

    mask_bank u_msk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (wr_msk),
        .load_val (bus_wdata),
        .msk_q    (msk_q)
    );

    // Enabled pending events.
    always_comb begin
        active = evt_q & msk_q;
    end

    group_reduce #(
        .N_GRP   (GRP_N),
        .GRP_VEC (GRP_PACK)
    ) u_red (
        .active  (active),
        .grp_hit (hit)
    );

    // Route group levels to the named lines.
    always_comb begin
        irq_tx  = hit[GRP_TX];
        irq_rx  = hit[GRP_RX];
        irq_err = hit[GRP_ERR];
    end

    // Read mux: zero unless a read of a known address is presented.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (bus_addr == A_EVT) begin
                bus_rdata = evt_q;
            end else if (bus_addr == A_MSK) begin
                bus_rdata = msk_q;
            end
        end
    end
endmodule

// File: rtl/evt_irq_agg_chk.sv
// Checker for the aggregator, attached by bind. Observes the port and the
// two register words. Assumes the top's default address parameters.
module evt_irq_agg_chk #(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned EVT_ADDR = 0,
    parameter int unsigned MSK_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       hw_set,
    input logic [31:0]       evt_q,
    input logic [31:0]       msk_q,
    input logic              irq_tx,
    input logic              irq_rx,
    input logic              irq_err
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MSK_ADDR);

    logic wr_e;
    logic wr_m;

    // Local decode of the port strobes.
    always_comb begin
        wr_e = bus_valid && bus_write && (bus_addr == A_EVT);
        wr_m = bus_valid && bus_write && (bus_addr == A_MSK);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (evt_q == '0 && msk_q == '0 && !irq_tx && !irq_rx && !irq_err));

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((evt_q & $past(hw_set)) == $past(hw_set)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && hw_set == '0) |=>
            (evt_q == ($past(evt_q) & ~$past(bus_wdata))));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && (hw_set & bus_wdata) != '0) |=>
            ((evt_q & $past(hw_set & bus_wdata)) == $past(hw_set & bus_wdata)));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m |=> (msk_q == $past(bus_wdata)));

    p_lines_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(evt_q) && $stable(msk_q)) |-> $stable({irq_tx, irq_rx, irq_err}));

    p_no_enable_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == '0) |-> (!irq_tx && !irq_rx && !irq_err));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_m |=> $stable(msk_q));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
    .ADDR_W   (ADDR_W),
    .EVT_ADDR (EVT_ADDR),
    .MSK_ADDR (MSK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_set    (hw_set),
    .evt_q     (evt_q),
    .msk_q     (msk_q),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err)
);

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of both registers, advanced at each
// rising edge and compared with the port every cycle.
module sim_evt_irq_agg;
    localparam logic [31:0] TXG = 32'h0000_00FF;
    localparam logic [31:0] RXG = 32'h0000_FF00;
    localparam logic [31:0] ERG = 32'h00FF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_set = '0;
    logic        irq_tx, irq_rx, irq_err;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [31:0] m_evt = '0;
    logic [31:0] m_msk = '0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    evt_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set(hw_set), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lines();
        logic [31:0] a;
        a = m_evt & m_msk;
        return {29'd0, |(a & TXG), |(a & RXG), |(a & ERG)};
    endfunction

    // One clock: drive at falling edge, check read data, advance model, check lines.
    task automatic step(input logic v, input logic w, input logic [1:0] a,
                        input logic [31:0] d, input logic [31:0] s, input string req);
        logic [31:0] exp_rd;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; hw_set = s;
        #1;
        exp_rd = '0;
        if (v && !w) exp_rd = (a == 2'd0) ? m_evt : (a == 2'd1) ? m_msk : '0;
        check({req, "/R6 read"}, bus_rdata, exp_rd);
        @(posedge clk);
        if (!rst_n) begin
            m_evt = '0; m_msk = '0;
        end else begin
            if (v && w && a == 2'd0) m_evt = m_evt & ~d;
            m_evt = m_evt | s;
            if (v && w && a == 2'd1) m_msk = d;
        end
        @(negedge clk);
        check({req, "/R7 lines"}, {29'd0, irq_tx, irq_rx, irq_err}, exp_lines());
    endtask

    // Combinational read-back in the current low phase, no edge consumed.
    task automatic peek(input logic [1:0] a, output logic [31:0] val);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0; hw_set = '0;
        #1 val = bus_rdata;
        bus_valid = 1'b0;
        #1;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset dominates set pulses and writes
        step(1, 1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
        step(0, 0, 2'd0, 0, 32'hFFFF_FFFF, "R1");
        rst_n = 1'b1;
        peek(2'd0, rd); check("R1 event after reset", rd, 32'h0);
        peek(2'd1, rd); check("R1 mask after reset", rd, 32'h0);
        check("R1 lines after reset", {29'd0, irq_tx, irq_rx, irq_err}, 32'h0);

        // R2: pulses accumulate, mask zero keeps lines low
        step(0, 0, 2'd0, 0, 32'h0000_0001, "R2");
        step(0, 0, 2'd0, 0, 32'h0000_0100, "R2");
        peek(2'd0, rd); check("R2 accumulate", rd, 32'h0000_0101);
        check("R7 masked off", {29'd0, irq_tx, irq_rx, irq_err}, 32'h0);

        // R5/R7: enable tx bit only
        step(1, 1, 2'd1, 32'h0000_0001, 0, "R5");
        check("R7 tx only", {29'd0, irq_tx, irq_rx, irq_err}, 32'h4);
        // R5: full replacement moves enable to rx
        step(1, 1, 2'd1, 32'h0000_0100, 0, "R5");
        peek(2'd1, rd); check("R5 replaced", rd, 32'h0000_0100);
        check("R7 rx only", {29'd0, irq_tx, irq_rx, irq_err}, 32'h2);

        // R3: clear rx bit, tx bit untouched
        step(1, 1, 2'd0, 32'h0000_0100, 0, "R3");
        peek(2'd0, rd); check("R3 w1c", rd, 32'h0000_0001);
        check("R3 rx dropped", {29'd0, irq_tx, irq_rx, irq_err}, 32'h0);

        // R4: clear and set of same bit in one cycle
        step(1, 1, 2'd0, 32'h0000_0001, 32'h0000_0001, "R4");
        peek(2'd0, rd); check("R4 set wins", rd, 32'h0000_0001);

        // R7: error group
        step(1, 1, 2'd1, 32'hFFFF_FFFF, 32'h0001_0000, "R7");
        check("R7 tx+err", {29'd0, irq_tx, irq_rx, irq_err}, 32'h5);

        // R8: only an ungrouped bit pending, fully enabled
        step(1, 1, 2'd0, 32'hFFFF_FFFF, 32'h8000_0000, "R8");
        peek(2'd0, rd); check("R8 bit held", rd, 32'h8000_0000);
        check("R8 no line", {29'd0, irq_tx, irq_rx, irq_err}, 32'h0);

        // R9: writes to unused addresses
        step(1, 1, 2'd2, 32'h0000_0000, 0, "R9");
        step(1, 1, 2'd3, 32'hFFFF_FFFF, 0, "R9");
        peek(2'd0, rd); check("R9 event kept", rd, 32'h8000_0000);
        peek(2'd1, rd); check("R9 mask kept", rd, 32'hFFFF_FFFF);

        // R10: write without valid
        step(0, 1, 2'd1, 32'h0, 0, "R10");
        step(0, 1, 2'd0, 32'hFFFF_FFFF, 0, "R10");
        peek(2'd1, rd); check("R10 mask kept", rd, 32'hFFFF_FFFF);
        peek(2'd0, rd); check("R10 event kept", rd, 32'h8000_0000);

        // R6: unused address reads zero, idle port reads zero
        step(1, 0, 2'd3, 0, 0, "R6");
        step(0, 0, 2'd0, 0, 0, "R6");

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[3:2], $urandom & $urandom, (r[7:4] == 0) ? $urandom : 32'h0, "R7 mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule